// File: doc/BRIEF.md
# Shift-Register Cascade Output Driver

This block feeds a chain of up to three external 8-bit serial-in, parallel-out shift registers from a 24-bit output image. Software writes the image through a small register port. A configuration word lets hardware status lines replace chosen low-order bits of that image. Two status lines come from a DSL modem core and three each come from two Ethernet PHY cores. The result is the composed image. Whenever the composed image differs from the value last sent to the chain, the block shifts it out and then pulses a store line so the external registers update their parallel outputs together.

The configuration word also sets which 8-bit groups are present in the chain and which shift-clock edge the external registers sample on. Bits leave the highest enabled group first, most significant bit first. The shift clock runs at the system clock divided by an even parameter. Data moves on the edge opposite the sampling edge, so it is stable at every sample.

The controller is one state machine with four states. ST_IDLE waits for a difference between the composed image and the last-sent copy. ST_SETUP holds the shift clock at its idle level with the current bit on the data line. ST_SAMPLE drives the sampling edge. ST_LATCH is the one-cycle store pulse. The transitions are:
- start: ST_IDLE to ST_SETUP, on a difference with at least one group enabled.
- half-up: ST_SETUP to ST_SAMPLE, after a half period.
- next-bit: ST_SAMPLE to ST_SETUP, after a half period when bits remain.
- last-bit: ST_SAMPLE to ST_LATCH, after the half period of the final bit.
- done: ST_LATCH to ST_IDLE.
- absorb: a self-loop in ST_IDLE that records a difference without shifting when the group mask is empty.

Top module: `shcas_top`

## Requirements
- R1: After reset, the software image equals the DEF_IMAGE parameter and the last-sent copy holds the same value. The group mask is DEF_GROUPS, all overrides are off and the sampling edge is DEF_RISE (0 means falling). sstore and sdata are 0, sclk sits at its idle level (1 for falling sampling), and no sequence runs while no input changes.
- R2: A write with wr_addr 0 loads the 24-bit software image. A write with wr_addr 1 loads the configuration from wr_data bits [11:0]: [2:0] group mask (bit g enables output bits 8g+7..8g), [4:3] DSL enables, [7:5] first-PHY enables, [10:8] second-PHY enables, [11] sampling edge (1 rising). Writes to addresses 2 and 3 change nothing.
- R3: Composed image bit i equals the status input when its enable is set, otherwise the software bit. DSL enable k drives bit k from dsl_stat[k]. First-PHY enable k drives bit 2+k from phya_stat[k]. Second-PHY enable k drives bit 5+k from phyb_stat[k].
- R4: A change of the composed image while idle starts a sequence, whether it comes from a software write, a configuration write or a status input.
- R5: A sequence shifts exactly 8 bits for each enabled group, from the highest enabled group down, each group most significant bit first. Disabled groups are skipped.
- R6: A store pulse exactly one cycle wide follows the last bit, with sclk back at its idle level.
- R7: Each sclk half period inside a sequence lasts CLK_DIV/2 system cycles.
- R8: With the sampling edge set to falling, sclk idles high. With it set to rising, sclk idles low. sdata changes only on the opposite edge, so it is stable when the sampling edge occurs.
- R9: Image changes during a sequence queue exactly one further sequence, which carries the latest composed image.
- R10: With an empty group mask, image changes produce no sclk, sdata or store activity, and the new image counts as already sent.
- R11: A status input whose enable is clear has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 image, 1 configuration |
| wr_data | input | 24 | Write data |
| dsl_stat | input | 2 | DSL core status bits |
| phya_stat | input | 3 | First PHY core status bits |
| phyb_stat | input | 3 | Second PHY core status bits |
| sclk | output | 1 | Shift clock to the cascade |
| sdata | output | 1 | Serial data to the cascade |
| sstore | output | 1 | Store pulse latching the parallel outputs |

## Verification
The assertions assume that the status inputs are synchronous to clk. They also assume that reset is asserted before the first active edge. The assertions read sclk only while a sequence is in progress, so the idle level may change with a configuration write at any time. The bench drives every input at the falling clock edge and keeps the status lines steady while it waits on a sequence. It writes the unmapped addresses only in the test dedicated to them. It changes the sampling edge only while the chain is quiet, so its own edge monitor never counts an idle-level change as a data bit.

// File: rtl/shcas_pkg.sv
package shcas_pkg;

    localparam int unsigned GRP_W     = 8;
    localparam int unsigned NUM_GRP   = 3;
    localparam int unsigned IMG_W     = GRP_W * NUM_GRP;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned DSL_BITS  = 2;
    localparam int unsigned PHY_BITS  = 3;
    localparam int unsigned DSL_LSB   = 0;
    localparam int unsigned PHYA_LSB  = DSL_LSB + DSL_BITS;
    localparam int unsigned PHYB_LSB  = PHYA_LSB + PHY_BITS;

    localparam logic [ADDR_W-1:0] ADDR_IMG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd1;

    typedef struct packed {
        logic                rise;
        logic [PHY_BITS-1:0] phyb_en;
        logic [PHY_BITS-1:0] phya_en;
        logic [DSL_BITS-1:0] dsl_en;
        logic [NUM_GRP-1:0]  grp_en;
    } shcas_cfg_t;

    localparam int unsigned CFG_W = $bits(shcas_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SAMPLE,
        ST_LATCH
    } shcas_state_e;

endpackage

// File: rtl/shcas_regs.sv
module shcas_regs
    import shcas_pkg::*;
#(
    parameter logic [IMG_W-1:0] DEF_IMAGE = '0,
    parameter shcas_cfg_t       DEF_CFG   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IMG_W-1:0]  wr_data,
    output logic [IMG_W-1:0]  sw_img,
    output shcas_cfg_t        cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_img <= DEF_IMAGE;
            cfg    <= DEF_CFG;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_IMG: sw_img <= wr_data;
                ADDR_CFG: cfg    <= shcas_cfg_t'(wr_data[CFG_W-1:0]);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/shcas_compose.sv
module shcas_compose
    import shcas_pkg::*;
(
    input  logic [IMG_W-1:0]    sw_img,
    input  shcas_cfg_t          cfg,
    input  logic [DSL_BITS-1:0] dsl_stat,
    input  logic [PHY_BITS-1:0] phya_stat,
    input  logic [PHY_BITS-1:0] phyb_stat,
    output logic [IMG_W-1:0]    img
);

    logic [IMG_W-1:0] ovr_en;
    logic [IMG_W-1:0] ovr_val;

    always_comb begin
        ovr_en  = '0;
        ovr_val = '0;
        ovr_en [DSL_LSB  +: DSL_BITS] = cfg.dsl_en;
        ovr_val[DSL_LSB  +: DSL_BITS] = dsl_stat;
        ovr_en [PHYA_LSB +: PHY_BITS] = cfg.phya_en;
        ovr_val[PHYA_LSB +: PHY_BITS] = phya_stat;
        ovr_en [PHYB_LSB +: PHY_BITS] = cfg.phyb_en;
        ovr_val[PHYB_LSB +: PHY_BITS] = phyb_stat;
    end

    // Per-bit source select: hardware status when enabled, software otherwise
    for (genvar b = 0; b < IMG_W; b++) begin : g_bit
        assign img[b] = ovr_en[b] ? ovr_val[b] : sw_img[b];
    end

endmodule

// File: rtl/shcas_shifter.sv
module shcas_shifter
    import shcas_pkg::*;
#(
    parameter int unsigned      CLK_DIV   = 4,
    parameter logic [IMG_W-1:0] DEF_IMAGE = '0,
    parameter logic             DEF_RISE  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IMG_W-1:0]   img,
    input  logic [NUM_GRP-1:0] grp_en,
    input  logic               rise,
    output logic               sclk,
    output logic               sdata,
    output logic               sstore,
    output logic               busy,
    output logic               rise_l,
    output logic [NUM_GRP-1:0] grp_l
);

    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned PW   = $clog2(IMG_W);
    localparam int unsigned GW   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    shcas_state_e     st, st_n;
    logic [IMG_W-1:0] sent;
    logic [IMG_W-1:0] shreg;
    logic [PW-1:0]    pos;
    logic [CW-1:0]    cnt;
    logic             half_done;
    logic             last_bit;
    logic             grp_edge;
    logic [GW:0]      top_hit;
    logic [GW:0]      low_hit;
    logic [GW-1:0]    cur_grp;

    // Highest enabled group index, with a found flag in the top bit
    function automatic logic [GW:0] highest_below(input logic [NUM_GRP-1:0] mask,
                                                  input int unsigned limit);
        logic [GW:0] r;
        r = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (g < int'(limit) && mask[g]) r = {1'b1, GW'(g)};
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] group_top_pos(input logic [GW-1:0] g);
        return PW'(int'(g) * GRP_W + GRP_W - 1);
    endfunction

    assign cur_grp   = GW'(int'(pos) / GRP_W);
    assign grp_edge  = ((int'(pos) % GRP_W) == 0);
    assign top_hit   = highest_below(grp_en, NUM_GRP);
    assign low_hit   = highest_below(grp_l, int'(cur_grp));
    assign half_done = (cnt == CW'(HALF - 1));
    assign last_bit  = grp_edge && !low_hit[GW];

    // Next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:   if (img != sent && grp_en != '0) st_n = ST_SETUP;
            ST_SETUP:  if (half_done) st_n = ST_SAMPLE;
            ST_SAMPLE: if (half_done) st_n = last_bit ? ST_LATCH : ST_SETUP;
            ST_LATCH:  st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Datapath: image snapshot, bit pointer, half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent   <= DEF_IMAGE;
            shreg  <= DEF_IMAGE;
            pos    <= '0;
            cnt    <= '0;
            grp_l  <= '0;
            rise_l <= DEF_RISE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    rise_l <= rise;
                    cnt    <= '0;
                    if (img != sent) begin
                        sent  <= img;
                        shreg <= img;
                        grp_l <= grp_en;
                        pos   <= group_top_pos(top_hit[GW-1:0]);
                    end
                end
                ST_SETUP: begin
                    cnt <= half_done ? '0 : cnt + 1'b1;
                end
                ST_SAMPLE: begin
                    if (half_done) begin
                        cnt <= '0;
                        if (!grp_edge)        pos <= pos - 1'b1;
                        else if (low_hit[GW]) pos <= group_top_pos(low_hit[GW-1:0]);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LATCH: begin
                    cnt <= '0;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        sclk   = ~rise_l;
        sdata  = 1'b0;
        sstore = 1'b0;
        busy   = 1'b1;
        unique case (st)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  sdata = shreg[pos];
            ST_SAMPLE: begin
                sclk  = rise_l;
                sdata = shreg[pos];
            end
            ST_LATCH:  sstore = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/shcas_top.sv
module shcas_top
    import shcas_pkg::*;
#(
    parameter int unsigned      CLK_DIV    = 4,
    parameter logic [IMG_W-1:0] DEF_IMAGE  = 24'h00FFFF,
    parameter logic [2:0]       DEF_GROUPS = 3'b111,
    parameter logic             DEF_RISE   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [IMG_W-1:0]    wr_data,
    input  logic [DSL_BITS-1:0] dsl_stat,
    input  logic [PHY_BITS-1:0] phya_stat,
    input  logic [PHY_BITS-1:0] phyb_stat,
    output logic                sclk,
    output logic                sdata,
    output logic                sstore
);

    localparam shcas_cfg_t DEF_CFG = '{
        rise:    DEF_RISE,
        phyb_en: '0,
        phya_en: '0,
        dsl_en:  '0,
        grp_en:  DEF_GROUPS
    };

    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
        $error("CLK_DIV must be even and at least 2");
    end

    logic [IMG_W-1:0]   sw_img;
    logic [IMG_W-1:0]   img;
    shcas_cfg_t         cfg;
    logic               shf_busy;
    logic               shf_rise;
    logic [NUM_GRP-1:0] shf_grp;

    shcas_regs #(
        .DEF_IMAGE (DEF_IMAGE),
        .DEF_CFG   (DEF_CFG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sw_img  (sw_img),
        .cfg     (cfg)
    );

    shcas_compose u_compose (
        .sw_img    (sw_img),
        .cfg       (cfg),
        .dsl_stat  (dsl_stat),
        .phya_stat (phya_stat),
        .phyb_stat (phyb_stat),
        .img       (img)
    );

    shcas_shifter #(
        .CLK_DIV   (CLK_DIV),
        .DEF_IMAGE (DEF_IMAGE),
        .DEF_RISE  (DEF_RISE)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .img    (img),
        .grp_en (cfg.grp_en),
        .rise   (cfg.rise),
        .sclk   (sclk),
        .sdata  (sdata),
        .sstore (sstore),
        .busy   (shf_busy),
        .rise_l (shf_rise),
        .grp_l  (shf_grp)
    );

endmodule

// File: rtl/shcas_chk.sv
module shcas_chk #(
    parameter int unsigned HALF    = 2,
    parameter int unsigned NUM_GRP = 3,
    parameter int unsigned GRP_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               sdata,
    input logic               sstore,
    input logic               busy,
    input logic               rise_l,
    input logic [NUM_GRP-1:0] grp_l
);

    logic        sclk_q;
    logic [7:0]  smp_cnt;
    logic [7:0]  tog_cnt;
    logic [15:0] run;

    always_ff @(posedge clk) sclk_q <= sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            tog_cnt <= '0;
            run     <= '0;
        end else begin
            if (!busy)                               smp_cnt <= '0;
            else if (sclk != sclk_q && sclk == rise_l) smp_cnt <= smp_cnt + 1'b1;

            if (!busy)                               tog_cnt <= '0;
            else if (sclk != sclk_q && tog_cnt != '1) tog_cnt <= tog_cnt + 1'b1;

            if (sclk != sclk_q)  run <= 16'd1;
            else if (run != '1)  run <= run + 1'b1;
        end
    end

    p_store_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sstore |=> !sstore);

    p_bit_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sstore |-> (smp_cnt == 8'($countones(grp_l) * GRP_W)));

    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk != sclk_q && sclk == rise_l) |-> $stable(sdata));

    p_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk != sclk_q && tog_cnt != '0) |-> (run == 16'(HALF)));

endmodule

bind shcas_top shcas_chk #(
    .HALF    (CLK_DIV / 2),
    .NUM_GRP (shcas_pkg::NUM_GRP),
    .GRP_W   (shcas_pkg::GRP_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk   (sclk),
    .sdata  (sdata),
    .sstore (sstore),
    .busy   (shf_busy),
    .rise_l (shf_rise),
    .grp_l  (shf_grp)
);

// File: tb/tb_shcas_top.sv
module tb_shcas_top;

    localparam int          DIV   = 4;
    localparam int          HALF  = DIV / 2;
    localparam logic [23:0] SHADOW = 24'h00FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  dsl_stat = '0;
    logic [2:0]  phya_stat = '0;
    logic [2:0]  phyb_stat = '0;
    logic        sclk, sdata, sstore;

    always #2.5 clk = ~clk;

    shcas_top #(
        .CLK_DIV    (DIV),
        .DEF_IMAGE  (SHADOW),
        .DEF_GROUPS (3'b111),
        .DEF_RISE   (1'b0)
    ) dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .dsl_stat (dsl_stat), .phya_stat (phya_stat),
        .phyb_stat (phyb_stat), .sclk (sclk), .sdata (sdata), .sstore (sstore)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic exp_rise = 1'b0;
    logic [23:0] cur_sw = SHADOW;
    logic [11:0] cur_cfg = 12'h007;

    // Serial monitor
    int          frames = 0;
    int          tog_total = 0;
    logic [23:0] mon_bits = '0;
    int          mon_cnt = 0;
    bit          in_frame = 1'b0;
    int          run = 0;
    int          iv_min = 1000;
    int          iv_max = 0;
    logic        sclk_prev = 1'b1;
    logic [23:0] fr_bits = '0;
    int          fr_cnt = 0, fr_min = 0, fr_max = 0;
    logic        fr_sclk = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk !== sclk_prev) begin
                tog_total++;
                if (in_frame) begin
                    if (run < iv_min) iv_min = run;
                    if (run > iv_max) iv_max = run;
                end
                if (sclk === exp_rise) begin
                    mon_bits = {mon_bits[22:0], sdata};
                    mon_cnt++;
                    in_frame = 1'b1;
                end
                run = 1;
            end else begin
                run++;
            end
            sclk_prev = sclk;
            if (sstore === 1'b1) begin
                fr_bits = mon_bits; fr_cnt = mon_cnt;
                fr_min = iv_min; fr_max = iv_max; fr_sclk = sclk;
                frames++;
                mon_bits = '0; mon_cnt = 0; in_frame = 1'b0;
                iv_min = 1000; iv_max = 0;
            end
        end else begin
            sclk_prev = sclk;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_bits(input logic [23:0] img, input logic [2:0] m);
        logic [23:0] r;
        r = '0;
        for (int g = 2; g >= 0; g--)
            if (m[g])
                for (int b = 7; b >= 0; b--) r = {r[22:0], img[g*8+b]};
        return r;
    endfunction

    function automatic logic [23:0] compose(input logic [23:0] sw, input logic [11:0] c);
        logic [23:0] r;
        r = sw;
        for (int i = 0; i < 2; i++) if (c[3+i]) r[i]   = dsl_stat[i];
        for (int i = 0; i < 3; i++) if (c[5+i]) r[2+i] = phya_stat[i];
        for (int i = 0; i < 3; i++) if (c[8+i]) r[5+i] = phyb_stat[i];
        return r;
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) cur_sw = d;
        if (a == 2'd1) cur_cfg = d[11:0];
    endtask

    task automatic expect_frame(input string req);
        int f;
        logic [23:0] img;
        f = frames;
        for (int i = 0; i < 400 && frames <= f; i++) @(negedge clk);
        @(negedge clk);
        img = compose(cur_sw, cur_cfg);
        chk(req, "store pulse seen", 32'(frames > f), 32'd1);
        chk("R5", "bit count", fr_cnt, 8 * $countones(cur_cfg[2:0]));
        chk(req, "shifted bits", fr_bits, exp_bits(img, cur_cfg[2:0]));
        chk("R7", "min half period", fr_min, HALF);
        chk("R7", "max half period", fr_max, HALF);
        chk("R6", "sclk idle at store", fr_sclk, !exp_rise);
    endtask

    task automatic expect_queued(input string req, input logic [23:0] img);
        int f;
        f = frames;
        for (int i = 0; i < 400 && frames <= f; i++) @(negedge clk);
        chk(req, "queued store seen", 32'(frames > f), 32'd1);
        chk(req, "queued bits", fr_bits, exp_bits(img, cur_cfg[2:0]));
    endtask

    task automatic quiet(input string req, input int cycles, input bit no_clk);
        int f, t;
        f = frames; t = tog_total;
        repeat (cycles) @(negedge clk);
        chk(req, "no store pulse", frames, f);
        if (no_clk) chk(req, "no sclk toggles", tog_total, t);
        chk(req, "sdata low", sdata, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "sclk idle high", sclk, 1'b1);
        chk("R1", "sdata", sdata, 1'b0);
        chk("R1", "sstore", sstore, 1'b0);
        quiet("R1", 100, 1'b1);
    endtask

    task automatic t_basic;
        reg_wr(2'd0, 24'hA5C33C);
        expect_frame("R4");
        quiet("R4", 100, 1'b0);
    endtask

    task automatic t_groups;
        reg_wr(2'd1, 24'h000005);
        quiet("R5", 50, 1'b1);
        reg_wr(2'd0, 24'h123456);
        expect_frame("R5");
        reg_wr(2'd1, 24'h000002);
        reg_wr(2'd0, 24'hFEDCBA);
        expect_frame("R5");
        reg_wr(2'd1, 24'h000007);
    endtask

    task automatic t_rising;
        exp_rise = 1'b1;
        reg_wr(2'd1, 24'h000807);
        repeat (3) @(negedge clk);
        chk("R8", "sclk idle low when rising", sclk, 1'b0);
        reg_wr(2'd0, 24'h0F0F33);
        expect_frame("R8");
        exp_rise = 1'b0;
        reg_wr(2'd1, 24'h000007);
        repeat (3) @(negedge clk);
        chk("R8", "sclk idle high when falling", sclk, 1'b1);
    endtask

    task automatic t_override;
        reg_wr(2'd0, 24'h3C0000);
        expect_frame("R4");
        @(negedge clk);
        dsl_stat = 2'b10; phya_stat = 3'b101; phyb_stat = 3'b011;
        quiet("R11", 150, 1'b1);
        reg_wr(2'd1, 24'h0007FF);
        expect_frame("R3");
        chk("R3", "low byte from status", fr_bits[7:0], 8'h76);
        @(negedge clk);
        phya_stat = 3'b010;
        expect_frame("R4");
        chk("R3", "low byte after phy change", fr_bits[7:0], 8'h6A);
        reg_wr(2'd1, 24'h00000F);
        expect_frame("R3");
        @(negedge clk);
        phyb_stat = 3'b100;
        quiet("R11", 150, 1'b1);
        @(negedge clk);
        dsl_stat = 2'b00;
        quiet("R11", 150, 1'b1);
        @(negedge clk);
        dsl_stat = 2'b01;
        expect_frame("R3");
        chk("R3", "low byte dsl bit", fr_bits[7:0], 8'h01);
        reg_wr(2'd1, 24'h000007);
        expect_frame("R3");
    endtask

    task automatic t_queue;
        reg_wr(2'd0, 24'h222222);
        repeat (10) @(negedge clk);
        reg_wr(2'd0, 24'h333333);
        repeat (10) @(negedge clk);
        reg_wr(2'd0, 24'h4C4C4C);
        expect_queued("R9", 24'h222222);
        expect_queued("R9", 24'h4C4C4C);
        quiet("R9", 250, 1'b1);
    endtask

    task automatic t_empty;
        reg_wr(2'd1, 24'h000000);
        reg_wr(2'd0, 24'h0ABCDE);
        quiet("R10", 200, 1'b1);
        reg_wr(2'd1, 24'h000007);
        quiet("R10", 150, 1'b1);
        reg_wr(2'd0, 24'h0ABCDF);
        expect_frame("R10");
    endtask

    task automatic t_badaddr;
        reg_wr(2'd2, 24'hFFFFFF);
        reg_wr(2'd3, 24'h000800);
        quiet("R2", 150, 1'b1);
        reg_wr(2'd0, 24'h5A5A01);
        expect_frame("R2");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_groups;
        t_rising;
        t_override;
        t_queue;
        t_empty;
        t_badaddr;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule